// File: doc/BRIEF.md
# Banked Covariance Update Writer

This block performs the final read-modify-write step of a covariance update: each cycle it takes up to four freshly computed product terms for one column of a square matrix, fetches the current covariance entries they belong to from four interleaved memory banks, subtracts each product from its entry, and writes each difference back to the bank and address it came from. The result is that every covariance entry is replaced by its old value minus the product. The products themselves are computed upstream and arrive as a stream of groups. Keeping the lower triangle symmetric is handled by another block.

A group is identified by a column index and a group index `s`. Lane `j` of group `s` carries matrix row `4s + j`, so row `r` always lives in bank `r mod 4`, which is the lane number. Within a bank, column `c` and group `s` share the word at `c * GROUPS + s`. With the default 159-row matrix there are 40 groups per column, and each bank holds 6360 words. The read for a group is issued in the cycle the group is accepted. The bank returns the word one cycle later, and the product is carried alongside the read so that the two meet for the subtraction. No input stalls are needed.

Top module: `cov_bank_writer`

## Requirements
- R1: Each written word equals the bank's old word minus the lane's product, in two's complement wrapping modulo 2^DW (old 0x00000010 minus product 0x00000015 gives 0xFFFFFFFB).
- R2: Lane j of every group reads and writes only bank j, so matrix row 4s+j is stored in bank (4s+j) mod 4.
- R3: The word address inside a bank is column * 40 + group (with the defaults DIM=159, LANES=4), for both the read and the write.
- R4: The read for an accepted group is issued in the same cycle as `in_valid`. The write of the result appears on the write port exactly two clock edges after the accepting edge, at the address that was read.
- R5: A new group can be accepted on every cycle, and all four lanes work in parallel. A full column of 40 back-to-back groups updates all 159 rows.
- R6: In the last group of a column (group 39), lanes whose row index is 159 or more are masked: lane 3 neither reads nor writes, and its bank word is left unchanged.
- R7: A group with column >= 159 or group >= 40 causes no read and no write on any bank.
- R8: While `in_valid` is low, no bank read or write is issued, whatever the other inputs hold.
- R9: Synchronous active-high reset drops any update still in flight. While reset is held and on the cycle after it, no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A product group is offered this cycle |
| in_col | input | CW (8) | Matrix column of the group |
| in_grp | input | GW (6) | Group index s within the column |
| in_prod | input | LANES*DW (128) | Product terms, lane j in bits [j*DW +: DW] |
| bank_rd_en | output | LANES (4) | Read strobe per bank |
| bank_rd_addr | output | LANES*AW (52) | Read word address per bank |
| bank_rd_data | input | LANES*DW (128) | Read data per bank, one cycle after the strobe |
| bank_wr_en | output | LANES (4) | Write strobe per bank |
| bank_wr_addr | output | LANES*AW (52) | Write word address per bank |
| bank_wr_data | output | LANES*DW (128) | Write data per bank |

## Verification
The hardest situation to reach from the ports is an update that is dropped while it is in flight. This needs a group that has already issued its read but not yet its write when reset arrives. The bench offers a group, raises reset on the very next edge, and then checks that the bank model still holds the original word. A second hard case is the partial final group of a column. It is reached both alone and at the end of a 40-group back-to-back stream, so that the masking of lane 3 is checked while every other lane is writing on every cycle.

// File: rtl/cov_upd_pkg.sv
package cov_upd_pkg;

    localparam int unsigned DIM_DEFAULT   = 159;
    localparam int unsigned LANES_DEFAULT = 4;
    localparam int unsigned DW_DEFAULT    = 32;

    // number of lane groups needed to cover one column
    function automatic int unsigned groups_per_col(input int unsigned dim,
                                                   input int unsigned lanes);
        return (dim + lanes - 1) / lanes;
    endfunction

    // width of a counter that must hold values 0 .. n-1 (at least 1 bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cov_slot_decode.sv
module cov_slot_decode
    import cov_upd_pkg::*;
#(
    parameter  int unsigned DIM    = DIM_DEFAULT,
    parameter  int unsigned LANES  = LANES_DEFAULT,
    localparam int unsigned GROUPS = groups_per_col(DIM, LANES),
    localparam int unsigned CW     = idx_width(DIM),
    localparam int unsigned GW     = idx_width(GROUPS),
    localparam int unsigned AW     = idx_width(DIM * GROUPS)
) (
    input  logic             valid,
    input  logic [CW-1:0]    col,
    input  logic [GW-1:0]    grp,
    output logic [LANES-1:0] lane_ok,
    output logic [AW-1:0]    addr
);

    logic in_range;

    always_comb begin
        in_range = valid && (32'(col) < 32'(DIM)) && (32'(grp) < 32'(GROUPS));
        addr     = AW'(col) * AW'(GROUPS) + AW'(grp);
    end

    // a lane is live only if its row lies inside the matrix
    for (genvar j = 0; j < LANES; j++) begin : g_mask
        assign lane_ok[j] = in_range &&
                            ((32'(grp) * 32'(LANES) + 32'(j)) < 32'(DIM));
    end

endmodule

// File: rtl/cov_lane_rmw.sv
module cov_lane_rmw
    import cov_upd_pkg::*;
#(
    parameter int unsigned DW = DW_DEFAULT,
    parameter int unsigned AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_vld,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_prod,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] prod;
    } wait_stage_t;

    wait_stage_t wait_q;

    // prefetch goes out in the accept cycle
    assign rd_en   = req_vld;
    assign rd_addr = req_addr;

    // hold the product one cycle so it meets the returning old word
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else begin
            wait_q.vld  <= req_vld;
            wait_q.addr <= req_addr;
            wait_q.prod <= req_prod;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= wait_q.vld;
            wr_addr <= wait_q.addr;
            wr_data <= rd_data - wait_q.prod;
        end
    end

endmodule

// File: rtl/cov_bank_writer.sv
module cov_bank_writer
    import cov_upd_pkg::*;
#(
    parameter  int unsigned DIM    = DIM_DEFAULT,
    parameter  int unsigned LANES  = LANES_DEFAULT,
    parameter  int unsigned DW     = DW_DEFAULT,
    localparam int unsigned GROUPS = groups_per_col(DIM, LANES),
    localparam int unsigned CW     = idx_width(DIM),
    localparam int unsigned GW     = idx_width(GROUPS),
    localparam int unsigned AW     = idx_width(DIM * GROUPS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [CW-1:0]       in_col,
    input  logic [GW-1:0]       in_grp,
    input  logic [LANES*DW-1:0] in_prod,
    output logic [LANES-1:0]    bank_rd_en,
    output logic [LANES*AW-1:0] bank_rd_addr,
    input  logic [LANES*DW-1:0] bank_rd_data,
    output logic [LANES-1:0]    bank_wr_en,
    output logic [LANES*AW-1:0] bank_wr_addr,
    output logic [LANES*DW-1:0] bank_wr_data
);

    logic [LANES-1:0] lane_ok;
    logic [AW-1:0]    word_addr;

    cov_slot_decode #(
        .DIM   (DIM),
        .LANES (LANES)
    ) u_decode (
        .valid   (in_valid),
        .col     (in_col),
        .grp     (in_grp),
        .lane_ok (lane_ok),
        .addr    (word_addr)
    );

    // lane j is hard-wired to bank j: row 4s+j mod 4 == j
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        cov_lane_rmw #(
            .DW (DW),
            .AW (AW)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .req_vld  (lane_ok[j]),
            .req_addr (word_addr),
            .req_prod (in_prod[j*DW +: DW]),
            .rd_en    (bank_rd_en[j]),
            .rd_addr  (bank_rd_addr[j*AW +: AW]),
            .rd_data  (bank_rd_data[j*DW +: DW]),
            .wr_en    (bank_wr_en[j]),
            .wr_addr  (bank_wr_addr[j*AW +: AW]),
            .wr_data  (bank_wr_data[j*DW +: DW])
        );
    end

endmodule

// File: rtl/cov_bank_writer_chk.sv
module cov_bank_writer_chk
    import cov_upd_pkg::*;
#(
    parameter  int unsigned DIM    = DIM_DEFAULT,
    parameter  int unsigned LANES  = LANES_DEFAULT,
    parameter  int unsigned DW     = DW_DEFAULT,
    localparam int unsigned GROUPS = groups_per_col(DIM, LANES),
    localparam int unsigned CW     = idx_width(DIM),
    localparam int unsigned GW     = idx_width(GROUPS),
    localparam int unsigned AW     = idx_width(DIM * GROUPS),
    localparam int unsigned TAIL   = DIM - (GROUPS - 1) * LANES
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [CW-1:0]       in_col,
    input logic [GW-1:0]       in_grp,
    input logic [LANES*DW-1:0] in_prod,
    input logic [LANES-1:0]    bank_rd_en,
    input logic [LANES*AW-1:0] bank_rd_addr,
    input logic [LANES*DW-1:0] bank_rd_data,
    input logic [LANES-1:0]    bank_wr_en,
    input logic [LANES*AW-1:0] bank_wr_addr,
    input logic [LANES*DW-1:0] bank_wr_data
);

    for (genvar j = 0; j < LANES; j++) begin : g_chk
        AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
            bank_wr_en[j] |-> $past(bank_rd_en[j], 2)) else $error("write without read"); // R4
        AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
            bank_wr_en[j] |-> bank_wr_addr[j*AW +: AW] == $past(bank_rd_addr[j*AW +: AW], 2)) else $error("write address moved"); // R4
        AST_WR_DIFF: assert property (@(posedge clk) disable iff (rst)
            bank_wr_en[j] |-> bank_wr_data[j*DW +: DW] ==
                $past(bank_rd_data[j*DW +: DW], 1) - $past(in_prod[j*DW +: DW], 2)) else $error("bad difference"); // R1
    end

    AST_TAIL_MASK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && 32'(in_col) < 32'(DIM) && 32'(in_grp) == 32'(GROUPS - 1))
            |-> $countones(bank_rd_en) == TAIL) else $error("tail not masked"); // R6
    AST_OOB_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (32'(in_col) >= 32'(DIM) || 32'(in_grp) >= 32'(GROUPS)))
            |-> bank_rd_en == '0) else $error("out of range read"); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> bank_rd_en == '0) else $error("idle read"); // R8
    AST_RST_FLUSH: assert property (@(posedge clk)
        rst |=> bank_wr_en == '0) else $error("write after reset"); // R9

endmodule

bind cov_bank_writer cov_bank_writer_chk #(
    .DIM   (DIM),
    .LANES (LANES),
    .DW    (DW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_col       (in_col),
    .in_grp       (in_grp),
    .in_prod      (in_prod),
    .bank_rd_en   (bank_rd_en),
    .bank_rd_addr (bank_rd_addr),
    .bank_rd_data (bank_rd_data),
    .bank_wr_en   (bank_wr_en),
    .bank_wr_addr (bank_wr_addr),
    .bank_wr_data (bank_wr_data)
);

// File: tb/test_cov_bank_writer.sv
module test_cov_bank_writer;

    localparam int DIM = 159, LANES = 4, DW = 32, GROUPS = 40;
    localparam int CW = 8, GW = 6, AW = 13;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [CW-1:0]       in_col = '0;
    logic [GW-1:0]       in_grp = '0;
    logic [LANES*DW-1:0] in_prod = '0;
    logic [LANES-1:0]    bank_rd_en;
    logic [LANES*AW-1:0] bank_rd_addr;
    logic [LANES*DW-1:0] bank_rd_data = '0;
    logic [LANES-1:0]    bank_wr_en;
    logic [LANES*AW-1:0] bank_wr_addr;
    logic [LANES*DW-1:0] bank_wr_data;

    int tests = 0;
    int fails = 0;

    logic [DW-1:0] mem [int];
    logic [DW-1:0] exp_mem [int];

    always #5 clk = ~clk;

    cov_bank_writer i_cov_bank_writer (
        .clk, .rst, .in_valid, .in_col, .in_grp, .in_prod,
        .bank_rd_en, .bank_rd_addr, .bank_rd_data,
        .bank_wr_en, .bank_wr_addr, .bank_wr_data
    );

    function automatic int key(input int b, input int a);
        return b * 8192 + a;
    endfunction

    function automatic logic [DW-1:0] init_val(input int b, input int a);
        return 32'(b) * 32'h0100_0000 + 32'(a) * 32'd977 + 32'h0000_0A5A;
    endfunction

    function automatic logic [DW-1:0] mem_get(input int b, input int a);
        return mem.exists(key(b, a)) ? mem[key(b, a)] : init_val(b, a);
    endfunction

    function automatic logic [DW-1:0] exp_get(input int b, input int a);
        return exp_mem.exists(key(b, a)) ? exp_mem[key(b, a)] : init_val(b, a);
    endfunction

    // bank model: registered read, write after read
    always @(posedge clk) begin
        for (int j = 0; j < LANES; j++) begin
            if (bank_rd_en[j])
                bank_rd_data[j*DW +: DW] <= mem_get(j, int'(bank_rd_addr[j*AW +: AW]));
            if (bank_wr_en[j])
                mem[key(j, int'(bank_wr_addr[j*AW +: AW]))] = bank_wr_data[j*DW +: DW];
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // offer one group at a negedge; model the expected result when apply is set
    task automatic offer(input int col, input int grp, input logic [LANES*DW-1:0] prod,
                         input bit apply);
        in_valid = 1'b1;
        in_col   = CW'(col);
        in_grp   = GW'(grp);
        in_prod  = prod;
        if (apply && col < DIM && grp < GROUPS) begin
            for (int j = 0; j < LANES; j++) begin
                if (grp * LANES + j < DIM)
                    exp_mem[key(j, col * GROUPS + grp)] =
                        exp_get(j, col * GROUPS + grp) - prod[j*DW +: DW];
            end
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check(bank_wr_en == '0, "R9", 128'(bank_wr_en), 0);
        check(bank_rd_en == '0, "R8", 128'(bank_rd_en), 0);
    endtask

    task automatic t_single;
        logic [LANES*DW-1:0] p;
        int a;
        a = 3 * GROUPS + 5;
        for (int j = 0; j < LANES; j++) p[j*DW +: DW] = 32'h0000_0111 * 32'(j + 1);
        @(negedge clk);
        offer(3, 5, p, 1'b1);
        #1;
        check(bank_rd_en == 4'hF, "R5", 128'(bank_rd_en), 128'hF);
        for (int j = 0; j < LANES; j++)
            check(int'(bank_rd_addr[j*AW +: AW]) == a, "R3",
                  128'(bank_rd_addr[j*AW +: AW]), 128'(a));
        @(negedge clk);
        in_valid = 1'b0;
        check(bank_wr_en == '0, "R4", 128'(bank_wr_en), 0);
        @(negedge clk);
        check(bank_wr_en == 4'hF, "R4", 128'(bank_wr_en), 128'hF);
        for (int j = 0; j < LANES; j++) begin
            check(int'(bank_wr_addr[j*AW +: AW]) == a, "R4",
                  128'(bank_wr_addr[j*AW +: AW]), 128'(a));
            check(bank_wr_data[j*DW +: DW] == exp_get(j, a), "R1",
                  128'(bank_wr_data[j*DW +: DW]), 128'(exp_get(j, a)));
        end
        @(negedge clk);
        for (int j = 0; j < LANES; j++)
            check(mem_get(j, a) == exp_get(j, a), "R2", 128'(mem_get(j, a)),
                  128'(exp_get(j, a)));
    endtask

    task automatic t_wrap;
        logic [LANES*DW-1:0] p;
        int a;
        a = 7 * GROUPS + 2;
        for (int j = 0; j < LANES; j++) p[j*DW +: DW] = exp_get(j, a) + 32'd5;
        @(negedge clk);
        offer(7, 2, p, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        idle_cycles(2);
        for (int j = 0; j < LANES; j++)
            check(mem_get(j, a) == 32'hFFFF_FFFB, "R1", 128'(mem_get(j, a)),
                  128'hFFFF_FFFB);
    endtask

    task automatic t_tail;
        logic [LANES*DW-1:0] p;
        int a;
        logic [DW-1:0] keep3;
        a = 10 * GROUPS + 39;
        keep3 = exp_get(3, a);
        for (int j = 0; j < LANES; j++) p[j*DW +: DW] = 32'h40 + 32'(j);
        @(negedge clk);
        offer(10, 39, p, 1'b1);
        #1;
        check(bank_rd_en == 4'b0111, "R6", 128'(bank_rd_en), 128'h7);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(bank_wr_en == 4'b0111, "R6", 128'(bank_wr_en), 128'h7);
        @(negedge clk);
        check(mem_get(3, a) == keep3, "R6", 128'(mem_get(3, a)), 128'(keep3));
        check(mem_get(0, a) == exp_get(0, a), "R1", 128'(mem_get(0, a)),
              128'(exp_get(0, a)));
    endtask

    task automatic t_stream;
        logic [LANES*DW-1:0] p;
        logic [DW-1:0] keep3;
        int busy;
        keep3 = exp_get(3, 158 * GROUPS + 39);
        busy = 0;
        for (int g = 0; g < GROUPS; g++) begin
            @(negedge clk);
            for (int j = 0; j < LANES; j++)
                p[j*DW +: DW] = 32'(g * 31 + j * 7 + 1);
            offer(158, g, p, 1'b1);
            if (g >= 2 && bank_wr_en == 4'hF) busy++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        idle_cycles(3);
        check(busy == GROUPS - 2, "R5", 128'(busy), 128'(GROUPS - 2));
        for (int r = 0; r < DIM; r++) begin
            int b, a;
            b = r % LANES;
            a = 158 * GROUPS + r / LANES;
            check(mem_get(b, a) == exp_get(b, a), "R5", 128'(mem_get(b, a)),
                  128'(exp_get(b, a)));
        end
        check(mem_get(3, 158 * GROUPS + 39) == keep3, "R6",
              128'(mem_get(3, 158 * GROUPS + 39)), 128'(keep3));
    endtask

    task automatic t_out_of_range;
        @(negedge clk);
        offer(159, 0, {LANES{32'h99}}, 1'b1);
        #1;
        check(bank_rd_en == '0, "R7", 128'(bank_rd_en), 0);
        @(negedge clk);
        offer(0, 40, {LANES{32'h99}}, 1'b1);
        #1;
        check(bank_rd_en == '0, "R7", 128'(bank_rd_en), 0);
        @(negedge clk);
        in_valid = 1'b0;
        check(bank_wr_en == '0, "R7", 128'(bank_wr_en), 0);
        @(negedge clk);
        check(bank_wr_en == '0, "R7", 128'(bank_wr_en), 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_valid = 1'b0;
        in_col   = 8'd20;
        in_grp   = 6'd4;
        in_prod  = {LANES{32'h1234}};
        #1;
        check(bank_rd_en == '0, "R8", 128'(bank_rd_en), 0);
        idle_cycles(2);
        check(bank_wr_en == '0, "R8", 128'(bank_wr_en), 0);
        check(mem_get(0, 20 * GROUPS + 4) == exp_get(0, 20 * GROUPS + 4), "R8",
              128'(mem_get(0, 20 * GROUPS + 4)), 128'(exp_get(0, 20 * GROUPS + 4)));
    endtask

    task automatic t_reset_flush;
        int a;
        a = 30 * GROUPS + 11;
        @(negedge clk);
        offer(30, 11, {LANES{32'h77}}, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(bank_wr_en == '0, "R9", 128'(bank_wr_en), 0);
        rst = 1'b0;
        idle_cycles(3);
        for (int j = 0; j < LANES; j++)
            check(mem_get(j, a) == init_val(j, a), "R9", 128'(mem_get(j, a)),
                  128'(init_val(j, a)));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle_cycles(3);
        t_reset;
        rst = 1'b0;
        idle_cycles(1);
        t_single;
        t_wrap;
        t_tail;
        t_stream;
        t_out_of_range;
        t_idle;
        t_reset_flush;
        idle_cycles(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule